// File: doc/BRIEF.md
# Three-Stage Timebase-Tap Watchdog

This block is a processor-style watchdog driven by a free-running 64-bit timebase. It does not count down from a reload value. A 6-bit period value instead picks one timebase bit to watch, and every 0-to-1 transition of that bit counts as one watchdog event. A smaller period value selects a more significant bit, which gives a longer interval.

Events move the watchdog up a three-step ladder. The first event sets an armed flag. The second sets an interrupt-status flag and, when the interrupt is enabled, drives an interrupt level. The third issues a one-cycle reset request, whose kind is chosen by a 2-bit reset-control field, and stores that field in a last-reset record. Software services the watchdog by writing ones to the two status flags. The timebase can be loaded and read through the same word-wide register port.

Top module: `tap_watchdog`

## Requirements
- R1: The timebase is a 64-bit counter that adds one in each cycle where `tick_en` is high. Address 2 reads and writes its low 32 bits, and address 3 reads and writes its high 32 bits. In a cycle with such a write, the write replaces the increment.
- R2: In the control register (address 0), the period P is formed from bits [20:17] (upper four bits) and bits [31:30] (lower two bits). P taps timebase bit 63-P. A 0-to-1 change of the tapped bit is one event, so events come every 2^(64-P) ticks, and P=0 watches bit 63.
- R3: An event while the armed flag (status bit 31) is clear sets that flag and changes nothing else.
- R4: An event while the armed flag is set and the interrupt flag (status bit 30) is clear sets the interrupt flag. `wd_irq` is high exactly while the interrupt flag and the interrupt-enable bit (control bit 27) are both 1.
- R5: An event while both flags are set copies the reset-control field (control bits [29:28]) into the last-reset field (status bits [29:28]). If that field is nonzero, the event also drives `wd_rst_req` high for exactly one cycle.
- R6: If the reset-control field is 00 at a third-stage event, `wd_rst_req` stays low.
- R7: Writing the status register (address 1) clears each flag whose bit is written as 1. Flags whose bits are written as 0 keep their value.
- R8: Once the reset-control field is nonzero, control writes leave it unchanged until reset. The period and interrupt-enable bits stay writable.
- R9: A change of P does not by itself produce an event in the cycle after the change, even when the newly tapped bit is 1 and the old one was 0.
- R10: After reset, every register reads 0 and `wd_irq` and `wd_rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timebase advance enable |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 timebase low, 3 timebase high |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| wd_irq | output | 1 | Watchdog interrupt level |
| wd_rst_req | output | 1 | One-cycle reset request |

## Verification
The checker tests properties on every cycle:
- the armed flag rises only after an event;
- the interrupt flag rises only when the armed flag is already set;
- the reset request lasts one cycle and follows a cycle in which both flags were set and the reset-control field was nonzero;
- a nonzero reset-control value never changes;
- a period change never produces an event in the same cycle.

Only the bench scenarios can show the rest:
- the exact tick counts between events for several periods;
- the split bit layout of the period field;
- that a write of zeros leaves the flags alone;
- that retapping onto a bit that is already high stays quiet.

// File: rtl/tap_wd_pkg.sv
// Package: shared constants, register layout and helpers for the
// timebase-tap watchdog. Assumes a 32-bit register port and a timebase that
// is exactly two register words wide.
package tap_wd_pkg;

    localparam int DATA_W  = 32;
    localparam int TB_W    = 64;
    localparam int PER_W   = 6;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_TB_LO = 2'd2;
    localparam logic [ADDR_W-1:0] A_TB_HI = 2'd3;

    // control word bit positions
    localparam int C_PLO_HI = 31;
    localparam int C_PLO_LO = 30;
    localparam int C_RC_HI  = 29;
    localparam int C_RC_LO  = 28;
    localparam int C_IEN    = 27;
    localparam int C_PHI_HI = 20;
    localparam int C_PHI_LO = 17;

    // status word bit positions
    localparam int S_ARM    = 31;
    localparam int S_INT    = 30;
    localparam int S_LR_HI  = 29;
    localparam int S_LR_LO  = 28;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic             irq_en;
        logic [1:0]       rst_ctl;
    } ctrl_t;

    // Pull the split period field out of a control word.
    function automatic logic [PER_W-1:0] word_to_period(input logic [DATA_W-1:0] w);
        return {w[C_PHI_HI:C_PHI_LO], w[C_PLO_HI:C_PLO_LO]};
    endfunction

    // Pack the control register into its word layout.
    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[C_PLO_HI:C_PLO_LO] = c.period[1:0];
        w[C_PHI_HI:C_PHI_LO] = c.period[PER_W-1:2];
        w[C_RC_HI:C_RC_LO]   = c.rst_ctl;
        w[C_IEN]             = c.irq_en;
        return w;
    endfunction

endpackage

// File: rtl/tap_wd_timebase.sv
// Timebase: a free-running counter of TB_W bits that advances on tick_en and
// can be loaded one DATA_W word at a time. Assumes TB_W == 2*DATA_W.
// A load has priority over the increment in the same cycle.
module tap_wd_timebase #(
    parameter int TB_W   = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [TB_W-1:0]   tb
);
    localparam int LO_W = DATA_W;
    localparam int HI_W = TB_W - DATA_W;

    logic [TB_W-1:0] tb_q;

    // Count, or take a word load from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else if (load_lo) begin
            tb_q[LO_W-1:0] <= wdata;
        end else if (load_hi) begin
            tb_q[TB_W-1:LO_W] <= wdata[HI_W-1:0];
        end else if (tick_en) begin
            tb_q <= tb_q + 1'b1;
        end
    end

    assign tb = tb_q;
endmodule

// File: rtl/tap_wd_edge.sv
// Tap and edge detector: selects timebase bit (TB_W-1-period) and flags a
// 0-to-1 change against the value seen in the previous cycle. If the period
// differs from the previous cycle's, the comparison is void and no event is
// raised; the stored value is simply reloaded.
module tap_wd_edge #(
    parameter int TB_W  = 64,
    parameter int PER_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TB_W-1:0]  tb,
    input  logic [PER_W-1:0] period,
    output logic             wd_event
);
    localparam int IDX_W = $clog2(TB_W);

    logic [IDX_W-1:0] idx;
    logic             tap_now;
    logic             tap_prev;
    logic [PER_W-1:0] per_prev;

    // Map period to bit index: larger period, less significant bit.
    assign idx     = IDX_W'(TB_W - 1) - IDX_W'(period);
    assign tap_now = tb[idx];

    // Remember the tapped bit and the period it was taken with.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_prev <= 1'b0;
            per_prev <= '0;
        end else begin
            tap_prev <= tap_now;
            per_prev <= period;
        end
    end

    // Rising edge, valid only when the tap did not move.
    assign wd_event = tap_now && !tap_prev && (period == per_prev);
endmodule

// File: rtl/tap_wd_ctrl.sv
// Control register: period, interrupt enable and reset-control. The
// reset-control field accepts a write only while it is still zero.
module tap_wd_ctrl
    import tap_wd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_q;

    // Update fields on a write; reset-control sticks once nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q.period <= word_to_period(wdata);
            ctrl_q.irq_en <= wdata[C_IEN];
            if (ctrl_q.rst_ctl == 2'b00) begin
                ctrl_q.rst_ctl <= wdata[C_RC_HI:C_RC_LO];
            end
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/tap_wd_ladder.sv
// Escalation ladder: armed flag, interrupt flag, last-reset record and the
// reset-request pulse. Each event moves one step; flag clears from the
// status write are applied after the event update, so a clear wins over a
// set of the same flag in one cycle.
module tap_wd_ladder (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_event,
    input  logic       clr_arm,
    input  logic       clr_int,
    input  logic       irq_en,
    input  logic [1:0] rst_ctl,
    output logic       arm,
    output logic       int_flag,
    output logic [1:0] last_rst,
    output logic       irq,
    output logic       rst_req
);
    logic       arm_q, int_q, req_q;
    logic [1:0] lr_q;
    logic       arm_d, int_d, req_d;
    logic [1:0] lr_d;

    // Next-state: one ladder step per event, then software clears.
    always_comb begin
        arm_d = arm_q;
        int_d = int_q;
        lr_d  = lr_q;
        req_d = 1'b0;
        if (wd_event) begin
            if (!arm_q) begin
                arm_d = 1'b1;
            end else if (!int_q) begin
                int_d = 1'b1;
            end else begin
                lr_d  = rst_ctl;
                req_d = (rst_ctl != 2'b00);
            end
        end
        if (clr_arm) arm_d = 1'b0;
        if (clr_int) int_d = 1'b0;
    end

    // State registers and the one-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            int_q <= 1'b0;
            lr_q  <= 2'b00;
            req_q <= 1'b0;
        end else begin
            arm_q <= arm_d;
            int_q <= int_d;
            lr_q  <= lr_d;
            req_q <= req_d;
        end
    end

    assign arm      = arm_q;
    assign int_flag = int_q;
    assign last_rst = lr_q;
    assign irq      = int_q & irq_en;
    assign rst_req  = req_q;
endmodule

// File: rtl/tap_watchdog.sv
// Top: timebase-tap watchdog with a word-wide register port. Writes take
// effect at the clock edge; reads are combinational on reg_addr.
module tap_watchdog
    import tap_wd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wd_irq,
    output logic              wd_rst_req
);
    ctrl_t           ctrl_w;
    logic [TB_W-1:0] tb_w;
    logic            ev_w;
    logic            arm_w, int_w;
    logic [1:0]      lr_w;
    logic            wr_ctrl, wr_stat, wr_lo, wr_hi;

    // Decode register writes.
    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign wr_stat = reg_we && (reg_addr == A_STAT);
    assign wr_lo   = reg_we && (reg_addr == A_TB_LO);
    assign wr_hi   = reg_we && (reg_addr == A_TB_HI);

    tap_wd_timebase #(.TB_W(TB_W), .DATA_W(DATA_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .load_lo(wr_lo), .load_hi(wr_hi), .wdata(reg_wdata), .tb(tb_w)
    );

    tap_wd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(reg_wdata), .ctrl(ctrl_w)
    );

    tap_wd_edge #(.TB_W(TB_W), .PER_W(PER_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .tb(tb_w), .period(ctrl_w.period), .wd_event(ev_w)
    );

    tap_wd_ladder u_ladder (
        .clk(clk), .rst_n(rst_n), .wd_event(ev_w),
        .clr_arm(wr_stat && reg_wdata[S_ARM]),
        .clr_int(wr_stat && reg_wdata[S_INT]),
        .irq_en(ctrl_w.irq_en), .rst_ctl(ctrl_w.rst_ctl),
        .arm(arm_w), .int_flag(int_w), .last_rst(lr_w),
        .irq(wd_irq), .rst_req(wd_rst_req)
    );

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_to_word(ctrl_w);
            A_STAT: begin
                reg_rdata[S_ARM]           = arm_w;
                reg_rdata[S_INT]           = int_w;
                reg_rdata[S_LR_HI:S_LR_LO] = lr_w;
            end
            A_TB_LO: reg_rdata = tb_w[DATA_W-1:0];
            default: reg_rdata = tb_w[TB_W-1:DATA_W];
        endcase
    end
endmodule

// File: rtl/tap_wd_chk.sv
// Checker: cycle-level properties of the watchdog ladder, bound to the top.
module tap_wd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wd_event,
    input logic       arm,
    input logic       int_flag,
    input logic [1:0] rst_ctl,
    input logic [5:0] period,
    input logic       irq,
    input logic       rst_req
);
    // R3
    arm_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm) |-> $past(wd_event));

    // R4
    int_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flag) |-> ($past(arm) && $past(wd_event)));

    // R4
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_flag);

    // R5
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(arm) && $past(int_flag) && $past(wd_event)));

    // R6
    req_needs_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(rst_ctl) != 2'b00));

    // R8
    rst_ctl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_ctl) != 2'b00) |-> (rst_ctl == $past(rst_ctl)));

    // R9
    retap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period != $past(period)) |-> !wd_event);
endmodule

bind tap_watchdog tap_wd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wd_event(ev_w), .arm(arm_w), .int_flag(int_w),
    .rst_ctl(ctrl_w.rst_ctl), .period(ctrl_w.period), .irq(wd_irq),
    .rst_req(wd_rst_req)
);

// File: tb/sim_tap_watchdog.sv
module sim_tap_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        wd_irq, wd_rst_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tap_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
    );

    always @(posedge clk) if (rst_n && wd_rst_req) pulses++;

    function automatic logic [31:0] cw(input logic [5:0] p, input logic ie, input logic [1:0] rc);
        return {p[1:0], rc, ie, 6'b0, p[5:2], 17'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pulses = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(2'd0, d); chk("R10 ctrl", d, 0);
        rd(2'd1, d); chk("R10 stat", d, 0);
        rd(2'd2, d); chk("R10 tb lo", d, 0);
        chk("R10 irq", {31'b0, wd_irq}, 0);
        chk("R10 req", {31'b0, wd_rst_req}, 0);
    endtask

    task automatic t_timebase();
        logic [31:0] d;
        do_reset();
        wr(2'd2, 32'hFFFF_FFFE);
        wr(2'd3, 32'h0000_0010);
        tick(3);
        rd(2'd2, d); chk("R1 lo wrap", d, 32'h0000_0001);
        rd(2'd3, d); chk("R1 hi carry", d, 32'h0000_0011);
    endtask

    task automatic t_ladder();
        logic [31:0] d;
        do_reset();
        wr(2'd0, cw(6'd62, 1'b1, 2'd2));
        rd(2'd0, d); chk("R2 ctrl layout", d, cw(6'd62, 1'b1, 2'd2));
        tick(1);
        rd(2'd1, d); chk("R2 no event before bit1 rises", d, 0);
        tick(1);
        rd(2'd1, d); chk("R3 first event arms only", d, 32'h8000_0000);
        chk("R3 no irq", {31'b0, wd_irq}, 0);
        tick(4);
        rd(2'd1, d); chk("R4 second event", d, 32'hC000_0000);
        chk("R4 irq level", {31'b0, wd_irq}, 1);
        tick(4);
        chk("R5 one pulse", pulses, 1);
        rd(2'd1, d); chk("R5 record", d, 32'hE000_0000);
        tick(4);
        chk("R5 pulse per third-stage event", pulses, 2);
    endtask

    task automatic t_irq_mask_and_clear();
        logic [31:0] d;
        do_reset();
        wr(2'd0, cw(6'd62, 1'b0, 2'd1));
        tick(6);
        chk("R4 masked irq", {31'b0, wd_irq}, 0);
        wr(2'd0, cw(6'd62, 1'b1, 2'd1));
        chk("R4 irq after enable", {31'b0, wd_irq}, 1);
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, d); chk("R7 zero write keeps", d, 32'hC000_0000);
        wr(2'd1, 32'h4000_0000);
        rd(2'd1, d); chk("R7 clear int only", d, 32'h8000_0000);
        chk("R7 irq drops", {31'b0, wd_irq}, 0);
        wr(2'd1, 32'h8000_0000);
        rd(2'd1, d); chk("R7 clear arm", d, 0);
    endtask

    task automatic t_no_ctl();
        logic [31:0] d;
        do_reset();
        wr(2'd0, cw(6'd62, 1'b1, 2'd0));
        tick(10);
        chk("R6 no pulse", pulses, 0);
        rd(2'd1, d); chk("R6 status", d, 32'hC000_0000);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        wr(2'd0, cw(6'd62, 1'b0, 2'd2));
        wr(2'd0, cw(6'd63, 1'b1, 2'd1));
        rd(2'd0, d); chk("R8 locked, others move", d, cw(6'd63, 1'b1, 2'd2));
        wr(2'd0, cw(6'd5, 1'b0, 2'd0));
        rd(2'd0, d); chk("R8 zero write ignored", d, cw(6'd5, 1'b0, 2'd2));
    endtask

    task automatic t_retap();
        logic [31:0] d;
        do_reset();
        wr(2'd0, cw(6'd62, 1'b0, 2'd0));
        wr(2'd2, 32'h0000_0020);
        repeat (2) @(negedge clk);
        wr(2'd0, cw(6'd58, 1'b0, 2'd0));
        repeat (3) @(negedge clk);
        rd(2'd1, d); chk("R9 retap quiet", d, 0);
    endtask

    task automatic t_periods();
        logic [31:0] d;
        do_reset();
        wr(2'd0, cw(6'd63, 1'b0, 2'd0));
        tick(1);
        rd(2'd1, d); chk("R2 P=63 first event", d, 32'h8000_0000);
        tick(2);
        rd(2'd1, d); chk("R2 P=63 interval 2", d, 32'hC000_0000);
        do_reset();
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'h7FFF_FFFF);
        wr(2'd0, cw(6'd0, 1'b0, 2'd0));
        repeat (2) @(negedge clk);
        rd(2'd1, d); chk("R2 P=0 idle", d, 0);
        tick(1);
        rd(2'd1, d); chk("R2 P=0 taps bit 63", d, 32'h8000_0000);
    endtask

    initial begin
        t_reset();
        t_timebase();
        t_ladder();
        t_irq_mask_and_clear();
        t_no_ctl();
        t_lock();
        t_retap();
        t_periods();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule